// File: doc/BRIEF.md
# Cascadable Product-Term Sum Array

This block is the combinational logic core of a row of programmable-logic macrocells, arranged as several independent chains. Each macrocell builds five AND terms over its chain's input set. That set is the chain's selected input signals plus one foldback bit from every macrocell in the same chain. Every literal of every term has a two-bit code that selects true, complement, ignore or kill.

Each term is either summed by the macrocell's OR gate or stolen and sent out as a control term. The OR result may absorb the sum of the previous macrocell in the chain, so a sum can grow to every term in the chain. A polarity stage then XORs the sum with a constant or with the macrocell's first term.

The foldback bits are registered, so the foldback path cannot form a combinational loop. All configuration inputs are static while the array operates.

Top module: `pts_sum_array`

## Requirements
- R1: A term is the AND of its literals. Literal i of the term for steering bit b is `term_cfg[b*2*NIN + 2*i +: 2]`, where NIN = SEL_W + MCS. The codes are: 00 ignores the input, 01 uses it true, 10 uses it complemented, and 11 forces the term to 0. A term whose literals are all 00 is 1. Literal i < SEL_W reads `sel_in[c*SEL_W + i]` for chain c. Literal SEL_W+j reads the foldback bit of macrocell j of the same chain.
- R2: Term t of macrocell k has steering bit b = k*TERMS+t. When `term_steal[b]` is 1, the term appears on `ctl_term[b]` and is kept out of the OR. When it is 0, `ctl_term[b]` is 0.
- R3: The local sum of a macrocell is the OR of its terms that are not stolen.
- R4: When `casc_en[k]` is 1 and macrocell k is not first in its chain, the sum of k is its local sum ORed with the full sum of macrocell k-1. When `casc_en[k]` is 0, the sum of k is its local sum.
- R5: The first macrocell of each chain (k a multiple of MCS) receives 0 on its cascade input, so no sum crosses from one chain to the next.
- R6: `mc_out[k]` is the sum XOR a polarity bit chosen by `pol_mode[2k+1:2k]`: 00 gives 0, 01 gives 1, and 10 or 11 gives term 0 of macrocell k, whether or not that term is stolen.
- R7: On every rising clock edge, `fb_bus[k]` loads the value of term TERMS-1 of macrocell k. A synchronous active-high `rst` clears `fb_bus` to 0.
- R8: With cascade enabled on all of its macrocells, one active term in the first macrocell of a chain drives every `mc_out` of that chain to 1. The sum then spans all MCS*TERMS terms of the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the foldback register |
| rst | input | 1 | Synchronous active-high reset of the foldback register |
| sel_in | input | N_CH*SEL_W (160) | Selected input signals, SEL_W per chain |
| term_cfg | input | N_CH*MCS*TERMS*2*NIN (15360) | Two-bit literal codes for every term |
| term_steal | input | N_CH*MCS*TERMS (160) | Per-term steering to control use |
| casc_en | input | N_CH*MCS (32) | Per-macrocell cascade enable |
| pol_mode | input | 2*N_CH*MCS (64) | Per-macrocell polarity selection |
| mc_out | output | N_CH*MCS (32) | Polarity-adjusted sum of each macrocell |
| ctl_term | output | N_CH*MCS*TERMS (160) | Stolen terms, 0 where not stolen |
| fb_bus | output | N_CH*MCS (32) | Registered foldback bits |

## Verification
Some properties are checked by assertions on every cycle:
- the gating of control terms;
- an all-ignore stolen term reading 1;
- a macrocell whose terms are all stolen producing only its polarity constant;
- a high sum passing through an enabled cascade link;
- the chain head refusing upstream sums;
- the foldback register loading the term it sees, and being cleared by reset.

The exact sum-of-products value under mixed true, complement and kill codes needs the bench's reference model. So do the terms that read foldback bits, a full-length cascade, and a cascade broken mid-chain. These are shown only by the bench's random and directed scenarios.

// File: rtl/pts_pkg.sv
package pts_pkg;

    localparam int N_CHAINS     = 4;
    localparam int MC_PER_CHAIN = 8;
    localparam int PT_PER_MC    = 5;
    localparam int SEL_WIDTH    = 40;

    typedef enum logic [1:0] {
        LIT_SKIP = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_INV  = 2'b10,
        LIT_KILL = 2'b11
    } lit_code_e;

    typedef enum logic [1:0] {
        POL_ZERO   = 2'b00,
        POL_ONE    = 2'b01,
        POL_TERM   = 2'b10,
        POL_TERM_B = 2'b11
    } pol_mode_e;

    typedef struct packed {
        logic       casc_en;
        logic [1:0] pol;
    } mc_ctl_t;

    function automatic logic lit_pass(input logic [1:0] code, input logic v);
        case (lit_code_e'(code))
            LIT_SKIP: return 1'b1;
            LIT_TRUE: return v;
            LIT_INV:  return ~v;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic pol_bit(input logic [1:0] mode, input logic pt);
        case (pol_mode_e'(mode))
            POL_ZERO: return 1'b0;
            POL_ONE:  return 1'b1;
            default:  return pt;
        endcase
    endfunction

endpackage

// File: rtl/pts_pterm.sv
module pts_pterm
    import pts_pkg::*;
#(
    parameter int NIN = SEL_WIDTH + MC_PER_CHAIN
) (
    input  logic [NIN-1:0]   lits,
    input  logic [2*NIN-1:0] codes,
    output logic             term
);

    logic [NIN-1:0] pass;

    for (genvar i = 0; i < NIN; i++) begin : g_lit
        assign pass[i] = lit_pass(codes[2*i +: 2], lits[i]);
    end

    assign term = &pass;

endmodule

// File: rtl/pts_macrocell.sv
module pts_macrocell
    import pts_pkg::*;
#(
    parameter int NIN       = SEL_WIDTH + MC_PER_CHAIN,
    parameter int TERMS     = PT_PER_MC,
    parameter int XOR_TERM  = 0,
    parameter int FOLD_TERM = PT_PER_MC - 1
) (
    input  logic [NIN-1:0]         lits,
    input  logic [TERMS*2*NIN-1:0] cfg,
    input  logic [TERMS-1:0]       steal,
    input  mc_ctl_t                ctl,
    input  logic                   casc_in,
    output logic                   sum_out,
    output logic                   pol_in,
    output logic [TERMS-1:0]       ctl_terms,
    output logic                   fold_out
);

    localparam int TCW = 2 * NIN;

    logic [TERMS-1:0] terms;
    logic             local_or;

    for (genvar t = 0; t < TERMS; t++) begin : g_term
        pts_pterm #(.NIN(NIN)) u_pterm (
            .lits  (lits),
            .codes (cfg[t*TCW +: TCW]),
            .term  (terms[t])
        );
    end

    assign local_or  = |(terms & ~steal);
    assign sum_out   = local_or | (ctl.casc_en & casc_in);
    assign pol_in    = pol_bit(ctl.pol, terms[XOR_TERM]);
    assign ctl_terms = terms & steal;
    assign fold_out  = terms[FOLD_TERM];

endmodule

// File: rtl/pts_chain.sv
module pts_chain
    import pts_pkg::*;
#(
    parameter  int SEL_W  = SEL_WIDTH,
    parameter  int MCS    = MC_PER_CHAIN,
    parameter  int TERMS  = PT_PER_MC,
    localparam int NIN    = SEL_W + MCS,
    localparam int MCFG_W = TERMS * 2 * NIN
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SEL_W-1:0]       sel_in,
    input  logic [MCS*MCFG_W-1:0]  cfg,
    input  logic [MCS*TERMS-1:0]   steal,
    input  logic [MCS-1:0]         casc_en,
    input  logic [2*MCS-1:0]       pol_mode,
    output logic [MCS-1:0]         mc_out,
    output logic [MCS*TERMS-1:0]   ctl_terms,
    output logic [MCS-1:0]         fb_q
);

    logic [NIN-1:0] lits;
    logic [MCS-1:0] sum;
    logic [MCS-1:0] pol_in;
    logic [MCS-1:0] fold;
    mc_ctl_t        ctl_v [MCS];

    assign lits = {fb_q, sel_in};

    for (genvar m = 0; m < MCS; m++) begin : g_mc
        logic casc_in;

        if (m == 0) begin : g_head
            assign casc_in = 1'b0;
        end else begin : g_link
            assign casc_in = sum[m-1];
        end

        assign ctl_v[m].casc_en = casc_en[m];
        assign ctl_v[m].pol     = pol_mode[2*m +: 2];

        pts_macrocell #(
            .NIN       (NIN),
            .TERMS     (TERMS),
            .XOR_TERM  (0),
            .FOLD_TERM (TERMS - 1)
        ) u_mc (
            .lits      (lits),
            .cfg       (cfg[m*MCFG_W +: MCFG_W]),
            .steal     (steal[m*TERMS +: TERMS]),
            .ctl       (ctl_v[m]),
            .casc_in   (casc_in),
            .sum_out   (sum[m]),
            .pol_in    (pol_in[m]),
            .ctl_terms (ctl_terms[m*TERMS +: TERMS]),
            .fold_out  (fold[m])
        );

        assign mc_out[m] = sum[m] ^ pol_in[m];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_q <= '0;
        end else begin
            fb_q <= fold;
        end
    end

endmodule

// File: rtl/pts_sum_array.sv
module pts_sum_array
    import pts_pkg::*;
#(
    parameter  int N_CH   = N_CHAINS,
    parameter  int MCS    = MC_PER_CHAIN,
    parameter  int TERMS  = PT_PER_MC,
    parameter  int SEL_W  = SEL_WIDTH,
    localparam int NIN    = SEL_W + MCS,
    localparam int CHCFG  = MCS * TERMS * 2 * NIN,
    localparam int N_MC   = N_CH * MCS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_CH*SEL_W-1:0]   sel_in,
    input  logic [N_CH*CHCFG-1:0]   term_cfg,
    input  logic [N_MC*TERMS-1:0]   term_steal,
    input  logic [N_MC-1:0]         casc_en,
    input  logic [2*N_MC-1:0]       pol_mode,
    output logic [N_MC-1:0]         mc_out,
    output logic [N_MC*TERMS-1:0]   ctl_term,
    output logic [N_MC-1:0]         fb_bus
);

    for (genvar c = 0; c < N_CH; c++) begin : g_chain
        pts_chain #(
            .SEL_W (SEL_W),
            .MCS   (MCS),
            .TERMS (TERMS)
        ) u_chain (
            .clk       (clk),
            .rst       (rst),
            .sel_in    (sel_in[c*SEL_W +: SEL_W]),
            .cfg       (term_cfg[c*CHCFG +: CHCFG]),
            .steal     (term_steal[c*MCS*TERMS +: MCS*TERMS]),
            .casc_en   (casc_en[c*MCS +: MCS]),
            .pol_mode  (pol_mode[2*c*MCS +: 2*MCS]),
            .mc_out    (mc_out[c*MCS +: MCS]),
            .ctl_terms (ctl_term[c*MCS*TERMS +: MCS*TERMS]),
            .fb_q      (fb_bus[c*MCS +: MCS])
        );
    end

endmodule

// File: rtl/pts_sum_array_chk.sv
module pts_sum_array_chk #(
    parameter  int N_CH  = 4,
    parameter  int MCS   = 8,
    parameter  int TERMS = 5,
    parameter  int SEL_W = 40,
    localparam int NIN   = SEL_W + MCS,
    localparam int TCW   = 2 * NIN,
    localparam int N_MC  = N_CH * MCS,
    localparam int FOLD  = TERMS - 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [N_MC*TERMS*TCW-1:0] term_cfg,
    input logic [N_MC*TERMS-1:0] term_steal,
    input logic [N_MC-1:0]       casc_en,
    input logic [2*N_MC-1:0]     pol_mode,
    input logic [N_MC-1:0]       mc_out,
    input logic [N_MC*TERMS-1:0] ctl_term,
    input logic [N_MC-1:0]       fb_bus
);

    // R7: one cycle after reset the foldback register reads zero
    a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fb_bus == '0));

    for (genvar k = 0; k < N_MC; k++) begin : g_k
        localparam bit HEAD = ((k % MCS) == 0);
        logic all_st;
        assign all_st = &term_steal[k*TERMS +: TERMS];

        if (HEAD) begin : g_head
            // R5: nothing reaches a chain head from upstream
            a_r5_chain_head: assert property (@(posedge clk) disable iff (rst)
                (all_st && pol_mode[2*k +: 2] == 2'b00) |-> !mc_out[k]);
        end else begin : g_body
            // R3: empty local sum with cascade off yields nothing
            a_r3_stolen_silent: assert property (@(posedge clk) disable iff (rst)
                (all_st && !casc_en[k] && pol_mode[2*k +: 2] == 2'b00) |-> !mc_out[k]);
            // R4: a high upstream sum passes an enabled link
            a_r4_casc_pass: assert property (@(posedge clk) disable iff (rst)
                (casc_en[k] && pol_mode[2*k +: 2] == 2'b00
                 && pol_mode[2*(k-1) +: 2] == 2'b00 && mc_out[k-1]) |-> mc_out[k]);
        end

        // R6: constant-high polarity over an empty sum gives 1
        a_r6_pol_high: assert property (@(posedge clk) disable iff (rst)
            (all_st && (HEAD || !casc_en[k]) && pol_mode[2*k +: 2] == 2'b01) |-> mc_out[k]);

        // R7: the register loads the fold term seen on the control port
        a_r7_fb_capture: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(term_steal[k*TERMS+FOLD]))
            |-> (fb_bus[k] == $past(ctl_term[k*TERMS+FOLD])));

        for (genvar t = 0; t < TERMS; t++) begin : g_t
            localparam int B = k*TERMS + t;
            // R2: unstolen terms never show on the control port
            a_r2_ctl_gate: assert property (@(posedge clk) disable iff (rst)
                !term_steal[B] |-> !ctl_term[B]);
            // R1: a stolen all-ignore term reads 1
            a_r1_blank_term: assert property (@(posedge clk) disable iff (rst)
                (term_steal[B] && term_cfg[B*TCW +: TCW] == '0) |-> ctl_term[B]);
        end
    end

endmodule

bind pts_sum_array pts_sum_array_chk #(
    .N_CH  (N_CH),
    .MCS   (MCS),
    .TERMS (TERMS),
    .SEL_W (SEL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .term_cfg   (term_cfg),
    .term_steal (term_steal),
    .casc_en    (casc_en),
    .pol_mode   (pol_mode),
    .mc_out     (mc_out),
    .ctl_term   (ctl_term),
    .fb_bus     (fb_bus)
);

// File: tb/pts_sum_array_bench.sv
module pts_sum_array_bench;
    import pts_pkg::*;

    localparam int NCH   = N_CHAINS;
    localparam int MCS   = MC_PER_CHAIN;
    localparam int TERMS = PT_PER_MC;
    localparam int SELW  = SEL_WIDTH;
    localparam int NIN   = SELW + MCS;
    localparam int TCW   = 2 * NIN;
    localparam int NMC   = NCH * MCS;
    localparam int NT    = NMC * TERMS;
    localparam int CFGW  = NT * TCW;
    localparam int FOLD  = TERMS - 1;

    // scenario table: {keep %, steal %, cascade %, cycles}
    localparam logic [31:0] SCEN [8] = '{
        {8'd3, 8'd20,  8'd50,  8'd12},
        {8'd5, 8'd0,   8'd100, 8'd12},
        {8'd2, 8'd50,  8'd30,  8'd12},
        {8'd8, 8'd10,  8'd80,  8'd12},
        {8'd0, 8'd30,  8'd60,  8'd8},
        {8'd4, 8'd100, 8'd0,   8'd8},
        {8'd6, 8'd0,   8'd0,   8'd12},
        {8'd3, 8'd40,  8'd90,  8'd12}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH*SELW-1:0] sel_in = '0;
    logic [CFGW-1:0] term_cfg = '0;
    logic [NT-1:0]   term_steal = '0;
    logic [NMC-1:0]  casc_en = '0;
    logic [2*NMC-1:0] pol_mode = '0;
    logic [NMC-1:0]  mc_out;
    logic [NT-1:0]   ctl_term;
    logic [NMC-1:0]  fb_bus;

    logic [NMC-1:0]  fb_m = '0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pts_sum_array u_pts_sum_array (
        .clk        (clk),
        .rst        (rst),
        .sel_in     (sel_in),
        .term_cfg   (term_cfg),
        .term_steal (term_steal),
        .casc_en    (casc_en),
        .pol_mode   (pol_mode),
        .mc_out     (mc_out),
        .ctl_term   (ctl_term),
        .fb_bus     (fb_bus)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic m_term(input int k, input int t);
        int c;
        int base;
        logic r;
        logic v;
        c = k / MCS;
        base = (k*TERMS + t) * TCW;
        r = 1'b1;
        for (int i = 0; i < NIN; i++) begin
            v = (i < SELW) ? sel_in[c*SELW + i] : fb_m[c*MCS + i - SELW];
            case (term_cfg[base + 2*i +: 2])
                2'b01:   r = r & v;
                2'b10:   r = r & ~v;
                2'b11:   r = 1'b0;
                default: r = r;
            endcase
        end
        return r;
    endfunction

    // compare with reference model at mid-cycle, then advance one clock
    task automatic cycle_check(input string req);
        logic [NMC-1:0] e_out;
        logic [NMC-1:0] e_fold;
        logic [NT-1:0]  e_ctl;
        logic prev;
        logic s;
        logic tv;
        logic pt;
        logic pb;
        e_out = '0; e_fold = '0; e_ctl = '0; prev = 1'b0; pt = 1'b0;
        for (int k = 0; k < NMC; k++) begin
            s = 1'b0;
            for (int t = 0; t < TERMS; t++) begin
                tv = m_term(k, t);
                if (t == 0) pt = tv;
                if (t == FOLD) e_fold[k] = tv;
                if (term_steal[k*TERMS + t]) e_ctl[k*TERMS + t] = tv;
                else s = s | tv;
            end
            if ((k % MCS) != 0 && casc_en[k]) s = s | prev;
            prev = s;
            pb = pol_mode[2*k+1] ? pt : pol_mode[2*k];
            e_out[k] = s ^ pb;
        end
        check({req, " mc_out"}, 256'(mc_out), 256'(e_out));
        check({req, " ctl_term R2"}, 256'(ctl_term), 256'(e_ctl));
        check({req, " fb_bus R7"}, 256'(fb_bus), 256'(fb_m));
        @(posedge clk);
        fb_m = e_fold;
        #1;
    endtask

    task automatic set_code(input int k, input int t, input int i, input logic [1:0] code);
        term_cfg[(k*TERMS + t)*TCW + 2*i +: 2] = code;
    endtask

    task automatic blank_term(input int k, input int t);
        term_cfg[(k*TERMS + t)*TCW +: TCW] = '0;
    endtask

    task automatic rand_cfg(input int keep, input int steal, input int casc);
        for (int b = 0; b < NT; b++) begin
            for (int i = 0; i < NIN; i++) begin
                if ($urandom_range(0, 99) < keep) begin
                    if ($urandom_range(0, 15) == 0) set_code(b / TERMS, b % TERMS, i, 2'b11);
                    else set_code(b / TERMS, b % TERMS, i, $urandom_range(0, 1) ? 2'b01 : 2'b10);
                end else begin
                    set_code(b / TERMS, b % TERMS, i, 2'b00);
                end
            end
            term_steal[b] = ($urandom_range(0, 99) < steal);
        end
        for (int k = 0; k < NMC; k++) begin
            casc_en[k] = ($urandom_range(0, 99) < casc);
            pol_mode[2*k +: 2] = 2'($urandom_range(0, 3));
        end
    endtask

    task automatic rand_inputs();
        for (int i = 0; i < NCH*SELW; i++) sel_in[i] = 1'($urandom_range(0, 1));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // reset state (R7)
        repeat (3) @(posedge clk);
        #4;
        check("R7 reset clears fb_bus", 256'(fb_bus), 256'(0));
        @(posedge clk);
        #1;
        rst = 1'b0;
        fb_m = '0;

        // table-driven random scenarios against the reference model
        for (int s = 0; s < 8; s++) begin
            rand_cfg(int'(SCEN[s][31:24]), int'(SCEN[s][23:16]), int'(SCEN[s][15:8]));
            for (int n = 0; n < int'(SCEN[s][7:0]); n++) begin
                rand_inputs();
                #3;
                cycle_check("R1/R3/R4/R6 random");
            end
        end

        // R1: all-ignore terms are 1, kill code gives 0
        term_cfg = '0; term_steal = '1; casc_en = '0; pol_mode = '0;
        #3;
        check("R1 blank terms", 256'(ctl_term), 256'({NT{1'b1}}));
        check("R3 all stolen sum", 256'(mc_out), 256'(0));
        cycle_check("R1 blank");
        term_cfg = '1;
        #3;
        check("R1 kill code", 256'(ctl_term), 256'(0));
        cycle_check("R1 kill");

        // R1: true and complement literals
        blank_term(0, 0);
        set_code(0, 0, 0, 2'b01);
        sel_in = '0; sel_in[0] = 1'b1;
        #3;
        check("R1 true literal high", 256'(ctl_term[0]), 256'(1));
        cycle_check("R1 true");
        sel_in[0] = 1'b0;
        #3;
        check("R1 true literal low", 256'(ctl_term[0]), 256'(0));
        cycle_check("R1 true");
        blank_term(0, 0);
        set_code(0, 0, 1, 2'b10);
        sel_in[1] = 1'b0;
        #3;
        check("R1 complement literal", 256'(ctl_term[0]), 256'(1));
        cycle_check("R1 compl");

        // R2/R3: only the unstolen term reaches the OR
        term_cfg = '0; term_steal = '1; term_steal[2] = 1'b0;
        #3;
        check("R3 single unstolen term", 256'(mc_out), 256'(1));
        check("R2 unstolen term off ctl", 256'(ctl_term), 256'({{(NT-3){1'b1}}, 3'b011}));
        cycle_check("R2/R3");

        // R8/R4/R5: full-length cascade and chain isolation
        term_cfg = '1; term_steal = '0; casc_en = '1; pol_mode = '0;
        blank_term(0, 3);
        #3;
        check("R8 full chain cascade", 256'(mc_out), 256'(32'h0000_00FF));
        cycle_check("R8");
        casc_en[4] = 1'b0;
        #3;
        check("R4 broken link", 256'(mc_out), 256'(32'h0000_000F));
        cycle_check("R4");
        casc_en = '1;
        term_cfg = '1;
        blank_term(7, 1);
        #3;
        check("R5 no crossing between chains", 256'(mc_out), 256'(32'h0000_0080));
        cycle_check("R5");

        // R6: polarity modes
        term_cfg = '0; term_steal = '1; casc_en = '0;
        pol_mode = {NMC{2'b01}};
        #3;
        check("R6 constant one", 256'(mc_out), 256'({NMC{1'b1}}));
        cycle_check("R6");
        pol_mode = {NMC{2'b10}};
        set_code(0, 0, 0, 2'b11);
        #3;
        check("R6 product-term polarity", 256'(mc_out), 256'(32'hFFFF_FFFE));
        cycle_check("R6");
        term_steal = '0;
        #3;
        check("R6 term inverts sum", 256'(mc_out), 256'(32'h0000_0001));
        cycle_check("R6");

        // R7: foldback capture and feed into a term
        term_cfg = '1; term_steal = '1; casc_en = '0; pol_mode = '0;
        blank_term(0, FOLD);
        blank_term(1, 0);
        set_code(1, 0, SELW, 2'b01);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        fb_m = '0;
        #3;
        check("R7 foldback term before clock", 256'(ctl_term[5]), 256'(0));
        cycle_check("R7");
        #3;
        check("R7 fb_bus loaded", 256'(fb_bus), 256'(1));
        check("R7 foldback read by term", 256'(ctl_term[5]), 256'(1));
        cycle_check("R7");
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        fb_m = '0;
        #2;
        check("R7 synchronous reset", 256'(fb_bus), 256'(0));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule